// File: doc/BRIEF.md
# Functional-Unit Issue Arbiter with Waiting-Tag Gating

This block decides which ready instructions from the issue queue start on the functional units of one group. The units in the group share a single set of result tag lines. Requests arrive as a vector ordered by age: index 0 is the oldest. Each request carries one bit that says whether the instruction will write a register tag. Each unit supplies one bit that says its tag latch still holds a tag that has not yet been broadcast. Units are served in ascending order. Each unit takes the oldest request that is still free and that it may accept. A unit with a held tag may still take an instruction that writes no tag, so its issue slot is not lost. It may never take an instruction that writes a tag, because that would overwrite the held tag.

An optional throttle mode limits the number of new tag writers the whole group may take in one cycle. The tags still held from the previous cycle count against a budget of `TAG_CAP` (parameter, 1 or 2, default 1). The grant decision is purely combinational. A registered copy of the grants is also provided to drive the tag-latch load enables in the next cycle.

Top module: `issue_grant_arbiter`

## Requirements
- R1: When `enable` is low, `grant` is all zero whatever the other inputs are. The registered copy is zero after the next clock edge.
- R2: Unit u takes the lowest-indexed request that is valid, not taken by a unit below u, and allowed for u. A request whose valid bit is clear is never granted. `grant` bit `u*NUM_REQ+r` means unit u takes request r.
- R3: Each unit receives at most one grant per cycle.
- R4: Each request is granted to at most one unit per cycle.
- R5: A unit whose `unit_wait` bit is 1 never receives a request whose `req_tag` bit is 1 (1 = the instruction writes a tag).
- R6: A unit whose `unit_wait` bit is 1 still receives the oldest free request whose `req_tag` bit is 0.
- R7: With `throttle_en` high, the number of tag-writing grants in a cycle plus the number of set `unit_wait` bits does not exceed `TAG_CAP`. When the held tags alone reach the cap, no tag-writing request is granted. Non-tag requests are still granted.
- R8: With `throttle_en` low, tag-writing grants are limited only by R5, with no group budget.
- R9: `grant_q` is zero in reset and afterwards equals `grant` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows grants this cycle |
| throttle_en | input | 1 | Turns on the group tag budget |
| req_valid | input | NUM_REQ | Ready requests; bit 0 is the oldest |
| req_tag | input | NUM_REQ | 1 = request writes a register tag |
| unit_wait | input | NUM_FU | 1 = unit still holds an unbroadcast tag |
| grant | output | NUM_FU*NUM_REQ | Combinational grants, one NUM_REQ-bit row per unit |
| grant_q | output | NUM_FU*NUM_REQ | Grants registered one cycle |

## Verification
The only internal state is the grant register. A wrong value there appears on `grant_q` one edge after the faulty `grant`, for example a stale grant after `enable` drops. All the priority, tag-gating and budget logic is combinational. A fault in the age order, the free-request chain or the tag budget therefore shows on `grant` in the same cycle as the inputs that expose it. The directed cases hold each input pattern for one cycle. They check the combinational row first and then the registered copy one edge later.

// File: rtl/iga_pkg.sv
package iga_pkg;

  // Tag-writing grants still allowed to the group, given the held tags.
  function automatic int tag_budget(input int cap, input int held);
    return (held < cap) ? (cap - held) : 0;
  endfunction

endpackage

// File: rtl/iga_unit_pick.sv
module iga_unit_pick #(
  parameter int NUM_REQ = 4
) (
  input  logic               enable,
  input  logic [NUM_REQ-1:0] free_req,
  input  logic [NUM_REQ-1:0] req_tag,
  input  logic               unit_wait,
  input  logic               tag_room,
  output logic [NUM_REQ-1:0] gnt,
  output logic               took_tag
);

  logic [NUM_REQ-1:0] tag_block;
  logic [NUM_REQ-1:0] elig;

  always_comb begin
    tag_block = req_tag & {NUM_REQ{unit_wait | ~tag_room}};
    elig      = free_req & ~tag_block;
    gnt       = enable ? (elig & (~elig + 1'b1)) : '0;
    took_tag  = |(gnt & req_tag);
  end

endmodule

// File: rtl/iga_grant_reg.sv
module iga_grant_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic         load;
  logic [W-1:0] q_nxt;
  logic         hist_ok;

  always_comb begin
    load  = enable | (|q);
    q_nxt = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_ok <= 1'b0;
    else        hist_ok <= 1'b1;
  end

  p_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ok |-> (q == $past(d)))
    else $error("grant_q is not last cycle grant");

endmodule

// File: rtl/issue_grant_arbiter.sv
module issue_grant_arbiter #(
  parameter int NUM_REQ = 4,
  parameter int NUM_FU  = 2,
  parameter int TAG_CAP = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      throttle_en,
  input  logic [NUM_REQ-1:0]        req_valid,
  input  logic [NUM_REQ-1:0]        req_tag,
  input  logic [NUM_FU-1:0]         unit_wait,
  output logic [NUM_FU*NUM_REQ-1:0] grant,
  output logic [NUM_FU*NUM_REQ-1:0] grant_q
);

  localparam int GW    = NUM_FU * NUM_REQ;
  localparam int CNT_W = $clog2(NUM_FU + 1) + 1;

  int                 budget;
  logic [NUM_REQ-1:0] taken [NUM_FU+1];
  logic [CNT_W-1:0]   used  [NUM_FU+1];
  logic [NUM_FU-1:0]  tag_vec;

  assign budget   = iga_pkg::tag_budget(TAG_CAP, $countones(unit_wait));
  assign taken[0] = '0;
  assign used[0]  = '0;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    logic [NUM_REQ-1:0] row;
    logic               room;
    logic               took;

    assign room = ~throttle_en | (int'(used[u]) < budget);

    iga_unit_pick #(.NUM_REQ(NUM_REQ)) i_pick (
      .enable   (enable),
      .free_req (req_valid & ~taken[u]),
      .req_tag  (req_tag),
      .unit_wait(unit_wait[u]),
      .tag_room (room),
      .gnt      (row),
      .took_tag (took)
    );

    assign taken[u+1]                 = taken[u] | row;
    assign used[u+1]                  = used[u] + CNT_W'(took);
    assign grant[u*NUM_REQ +: NUM_REQ] = row;
    assign tag_vec[u]                 = |(grant[u*NUM_REQ +: NUM_REQ] & req_tag);

    p_unit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant[u*NUM_REQ +: NUM_REQ]))
      else $error("unit has more than one grant");

    p_wait_no_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      unit_wait[u] |-> !(|(grant[u*NUM_REQ +: NUM_REQ] & req_tag)))
      else $error("waiting unit given tag writer");
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    logic [NUM_FU-1:0] col;
    for (genvar u = 0; u < NUM_FU; u++) begin : g_col
      assign col[u] = grant[u*NUM_REQ + r];
    end
    p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col))
      else $error("request granted twice");
  end

  iga_grant_reg #(.W(GW)) i_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(enable),
    .d     (grant),
    .q     (grant_q)
  );

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (grant == '0))
    else $error("grant while disabled");

  p_valid_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken[NUM_FU] & ~req_valid) == '0)
    else $error("invalid request granted");

  p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    throttle_en |-> (($countones(tag_vec) == 0) ||
                     ($countones(tag_vec) + $countones(unit_wait) <= TAG_CAP)))
    else $error("tag budget exceeded");

  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used[NUM_FU]) == $countones(tag_vec))
    else $error("tag count mismatch");

endmodule

// File: tb/test_issue_grant_arbiter.sv
module test_issue_grant_arbiter;

  localparam int NR = 4;
  localparam int NF = 2;

  logic          clk;
  logic          rst_n;
  logic          enable;
  logic          throttle_en;
  logic [NR-1:0] req_valid;
  logic [NR-1:0] req_tag;
  logic [NF-1:0] unit_wait;
  logic [7:0]    grant;
  logic [7:0]    grant_q;

  int checks = 0;
  int errors = 0;

  issue_grant_arbiter #(.NUM_REQ(NR), .NUM_FU(NF), .TAG_CAP(1)) i_issue_grant_arbiter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .throttle_en(throttle_en),
    .req_valid(req_valid), .req_tag(req_tag), .unit_wait(unit_wait),
    .grant(grant), .grant_q(grant_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one pattern, check grant in the cycle, grant_q after the edge.
  task automatic run_case(input string tag, input logic en, input logic thr,
                          input logic [3:0] rv, input logic [3:0] rt,
                          input logic [1:0] uw, input logic [7:0] exp);
    @(negedge clk);
    enable = en; throttle_en = thr; req_valid = rv; req_tag = rt; unit_wait = uw;
    #2;
    check({tag, " grant"}, grant, exp);
    @(posedge clk);
    #1;
    check({"R9 ", tag, " grant_q"}, grant_q, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b1; throttle_en = 1'b0;
    req_valid = 4'hF; req_tag = 4'h0; unit_wait = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset grant_q", grant_q, 8'h00);
    @(negedge clk);
    enable = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_disabled();
    run_case("R1 disabled", 1'b0, 1'b0, 4'hF, 4'h0, 2'b00, 8'h00);
  endtask

  task automatic t_age_order();
    run_case("R2 R3 R4 all ready", 1'b1, 1'b0, 4'hF, 4'h0, 2'b00, 8'h21);
    run_case("R2 sparse", 1'b1, 1'b0, 4'b1010, 4'h0, 2'b00, 8'h82);
    run_case("R2 single", 1'b1, 1'b0, 4'b0100, 4'h0, 2'b00, 8'h04);
  endtask

  task automatic t_wait_gating();
    run_case("R5 R6 unit0 waits", 1'b1, 1'b0, 4'hF, 4'b0001, 2'b01, 8'h12);
    run_case("R5 both wait tags", 1'b1, 1'b0, 4'b0011, 4'b0011, 2'b11, 8'h00);
    run_case("R6 both wait mixed", 1'b1, 1'b0, 4'b0111, 4'b0001, 2'b11, 8'h42);
  endtask

  task automatic t_throttle();
    run_case("R7 cap all tags", 1'b1, 1'b1, 4'hF, 4'hF, 2'b00, 8'h01);
    run_case("R7 cap skips to non-tag", 1'b1, 1'b1, 4'hF, 4'b1011, 2'b00, 8'h41);
    run_case("R7 held tag uses budget", 1'b1, 1'b1, 4'hF, 4'hF, 2'b10, 8'h00);
    run_case("R7 held tag non-tag ok", 1'b1, 1'b1, 4'hF, 4'b1110, 2'b10, 8'h01);
  endtask

  task automatic t_no_throttle();
    run_case("R8 no cap all tags", 1'b1, 1'b0, 4'hF, 4'hF, 2'b00, 8'h21);
    run_case("R8 no cap unit0 waits", 1'b1, 1'b0, 4'hF, 4'hF, 2'b01, 8'h10);
  endtask

  task automatic t_drop_enable();
    run_case("R1 R9 enable drops", 1'b0, 1'b1, 4'hF, 4'h0, 2'b00, 8'h00);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    t_reset();
    t_disabled();
    t_age_order();
    t_wait_gating();
    t_throttle();
    t_no_throttle();
    t_drop_enable();
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule